// File: doc/BRIEF.md
# Prescaled Real-Time Counter Core

This block is the counting engine of a real-time counter in its 32-bit mode. A slow timekeeping clock feeds a free-running 10-bit prescaler counter. A 4-bit select code picks how many prescaler clocks make up one count step, always a power of two from 1 to 1024. On each count step the 32-bit count advances by one. It can also return to zero when it equals a compare value. Each bit of the prescaler counter drives a periodic tap output, which gives a set of square-wave-derived pulses at fixed fractions of the input clock.

The block acts only when it is enabled and the 2-bit mode field selects 32-bit counting. In every other state the prescaler and the count keep their values. A load port can place any value into the count at any time. When the count passes the compare value, the block emits a one-clock match pulse. When it wraps past its all-ones value, it emits a one-clock overflow pulse.

Top module: `rtc_count_core`

## Requirements
- R1: While reset is low, and in the first cycle after it goes high, the count is 0 and the match, overflow and tap outputs are all 0.
- R2: Select codes 0x0 and 0x1 make the count advance on every active clock (divide by 1).
- R3: A select code c in 0x2..0xB makes the count advance once every 2^(c-1) active clocks. The step happens on the clock where the low c-1 bits of the prescaler counter are all ones.
- R4: Reserved select codes 0xC..0xF behave like code 0x0: divide by 1 with all tap outputs held at 0.
- R5: The prescaler counter advances by one on each active clock and wraps at 1024. Tap n pulses for one clock right after bit n of that counter rises. No tap pulses while the select code is 0x0 or reserved.
- R6: With the match-clear input high, a count step taken while the count equals the compare value loads 0 instead of count+1.
- R7: A count step taken while the count equals the compare value raises the match output for exactly the following clock. With match-clear low, the count goes on to compare+1.
- R8: A count step from 0xFFFFFFFF without a match-clear reset gives a count of 0 and raises the overflow output for that one clock.
- R9: When enable is low, or the mode field is not 0b00 (32-bit counting), the count and the prescaler counter hold and no pulses occur.
- R10: A load request writes the load value into the count on the next clock, even while inactive. It takes precedence over a count step in the same clock, and that clock gives no match or overflow pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timekeeping clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run enable |
| modeSel | input | 2 | Operating mode; 0b00 selects 32-bit counting |
| prescSel | input | 4 | Prescaler select code |
| matchClr | input | 1 | Return count to zero on compare match |
| cmpVal | input | 32 | Compare value |
| loadEn | input | 1 | Load request for the count |
| loadVal | input | 32 | Value written by a load request |
| count | output | 32 | Current count |
| matchPulse | output | 1 | One-clock compare match pulse |
| ovfPulse | output | 1 | One-clock wrap pulse |
| periodTap | output | 10 | One-clock pulses on each rising prescaler bit |

## Verification
The hardest cases to reach are the wrap from 0xFFFFFFFF, a match exactly at that value, and tap pulses on the upper prescaler bits. From reset these would need billions or about a thousand steps. The stimulus uses the load port to place the count a few steps below the wrap or the compare value. It then holds each divide code for three full periods, so the upper taps fire. A behavioural model runs next to the design and checks the count, both pulses and every tap on every clock, including while the block is disabled, in a non-32-bit mode and under reserved codes.

// File: rtl/rtc_core_pkg.sv
package rtc_core_pkg;
  // Mode field value that selects plain 32-bit counting
  localparam logic [1:0] MODE_COUNT32 = 2'b00;

  // Strobes from control to datapath, one per clock
  typedef struct packed {
    logic tick;   // count step this clock
    logic load;   // overwrite count with load value
  } cntStrobe_t;
endpackage

// File: rtl/rtc_prescale_ctrl.sv
module rtc_prescale_ctrl
  import rtc_core_pkg::*;
#(
  parameter int PRESC_W = 10,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         modeSel,
  input  logic [SEL_W-1:0]   prescSel,
  input  logic               loadEn,
  output cntStrobe_t         strb,
  output logic [PRESC_W-1:0] periodTap
);
  localparam int DEXP_W = $clog2(PRESC_W + 1);
  localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(PRESC_W + 1);
  localparam logic [SEL_W-1:0] CODE_ONE = SEL_W'(1);

  logic               active;
  logic               tapOff;
  logic [DEXP_W-1:0]  divExp;
  logic [PRESC_W-1:0] preCnt, preNext, rising, lowMask;
  logic [PRESC_W-1:0] tapQ;

  assign active = enable && (modeSel == MODE_COUNT32);

  // Decode select code into divide exponent and tap enable
  always_comb begin
    divExp = '0;
    tapOff = 1'b1;
    if (prescSel == CODE_ONE) begin
      tapOff = 1'b0;
    end else if (prescSel > CODE_ONE && prescSel <= MAX_CODE) begin
      divExp = DEXP_W'(prescSel - CODE_ONE);
      tapOff = 1'b0;
    end
  end

  assign lowMask = ~({PRESC_W{1'b1}} << divExp);
  assign preNext = preCnt + 1'b1;
  assign rising  = preNext & ~preCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      tapQ   <= '0;
    end else begin
      if (active) preCnt <= preNext;
      tapQ <= (active && !tapOff) ? rising : '0;
    end
  end

  assign strb.tick = active && ((preCnt & lowMask) == lowMask);
  assign strb.load = loadEn;
  assign periodTap = tapQ;

  AST_TAP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (prescSel == '0 || prescSel > MAX_CODE) |=> periodTap == '0); // R4
  AST_TAP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(periodTap)); // R5
  AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !active |=> $stable(preCnt)); // R9
endmodule

// File: rtl/rtc_count_dp.sv
module rtc_count_dp
  import rtc_core_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strb,
  input  logic             matchClr,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output logic             matchPulse,
  output logic             ovfPulse
);
  logic [CNT_W-1:0] cntQ;
  logic             matchQ, ovfQ;
  logic             hit, allOnes;

  assign hit     = (cntQ == cmpVal);
  assign allOnes = &cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      matchQ <= 1'b0;
      ovfQ   <= 1'b0;
    end else begin
      matchQ <= 1'b0;
      ovfQ   <= 1'b0;
      if (strb.load) begin
        cntQ <= loadVal;
      end else if (strb.tick) begin
        matchQ <= hit;
        if (matchClr && hit) begin
          cntQ <= '0;
        end else begin
          cntQ <= cntQ + 1'b1;
          ovfQ <= allOnes;
        end
      end
    end
  end

  assign count      = cntQ;
  assign matchPulse = matchQ;
  assign ovfPulse   = ovfQ;

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick && !strb.load && matchClr && hit) |=> count == '0); // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tick && !strb.load) |=> $stable(count)); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (count == $past(loadVal) && !matchPulse && !ovfPulse)); // R10
  AST_OVF_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> count == '0); // R8
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core
  import rtc_core_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter int PRESC_W = 10,
  parameter int SEL_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic [1:0]         modeSel,
  input  logic [SEL_W-1:0]   prescSel,
  input  logic               matchClr,
  input  logic [CNT_W-1:0]   cmpVal,
  input  logic               loadEn,
  input  logic [CNT_W-1:0]   loadVal,
  output logic [CNT_W-1:0]   count,
  output logic               matchPulse,
  output logic               ovfPulse,
  output logic [PRESC_W-1:0] periodTap
);
  cntStrobe_t strb;

  rtc_prescale_ctrl #(.PRESC_W(PRESC_W), .SEL_W(SEL_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .prescSel(prescSel), .loadEn(loadEn), .strb(strb), .periodTap(periodTap)
  );

  rtc_count_dp #(.CNT_W(CNT_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .matchClr(matchClr),
    .cmpVal(cmpVal), .loadVal(loadVal), .count(count),
    .matchPulse(matchPulse), .ovfPulse(ovfPulse)
  );
endmodule

// File: tb/test_rtc_count_core.sv
module test_rtc_count_core;
  localparam time HALF = 4ns;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  modeSel = 2'b00;
  logic [3:0]  prescSel = 4'h1;
  logic        matchClr = 1'b0;
  logic [31:0] cmpVal = 32'hFFFF_0000;
  logic        loadEn = 1'b0;
  logic [31:0] loadVal = '0;
  logic [31:0] count;
  logic        matchPulse, ovfPulse;
  logic [9:0]  periodTap;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string curReq = "R1";

  // reference model state
  logic [31:0] mCount = '0;
  int          mPc = 0;
  bit          mMatch = 0, mOvf = 0;
  logic [9:0]  mTap = '0;
  bit          act, tapsOn, tk;
  int          div, nPc;

  always #HALF clk = ~clk;

  rtc_count_core i_rtc_count_core (
    .clk(clk), .rstN(rstN), .enable(enable), .modeSel(modeSel),
    .prescSel(prescSel), .matchClr(matchClr), .cmpVal(cmpVal),
    .loadEn(loadEn), .loadVal(loadVal), .count(count),
    .matchPulse(matchPulse), .ovfPulse(ovfPulse), .periodTap(periodTap)
  );

  // Behavioural reference, advanced on every rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCount = '0; mPc = 0; mMatch = 0; mOvf = 0; mTap = '0;
    end else begin
      act    = enable && (modeSel == 2'b00);
      div    = (prescSel >= 2 && prescSel <= 11) ? (1 << (prescSel - 1)) : 1;
      tapsOn = (prescSel >= 1 && prescSel <= 11);
      tk     = act && ((mPc % div) == div - 1);
      mMatch = 0; mOvf = 0; mTap = '0;
      if (act) begin
        nPc = (mPc + 1) % 1024;
        if (tapsOn)
          for (int n = 0; n < 10; n++)
            mTap[n] = ((nPc >> n) & 1) == 1 && ((mPc >> n) & 1) == 0;
        mPc = nPc;
      end
      if (loadEn) mCount = loadVal;
      else if (tk) begin
        mMatch = (mCount == cmpVal);
        if (matchClr && mMatch) mCount = '0;
        else begin
          mOvf = (mCount == 32'hFFFF_FFFF);
          mCount = mCount + 1;
        end
      end
    end
  end

  task automatic compareAll();
    checks++;
    if (count !== mCount || matchPulse !== mMatch || ovfPulse !== mOvf || periodTap !== mTap) begin
      errors++;
      $display("FAIL %s: count=%h match=%b ovf=%b tap=%b expected count=%h match=%b ovf=%b tap=%b",
               curReq, count, matchPulse, ovfPulse, periodTap, mCount, mMatch, mOvf, mTap);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareAll();
    end
  endtask

  task automatic doLoad(logic [31:0] v);
    loadVal = v; loadEn = 1'b1;
    run(1);
    loadEn = 1'b0;
  endtask

  initial begin
    // R1: reset state
    run(3);
    @(negedge clk); rstN = 1'b1;
    curReq = "R1";
    run(1);
    checks++;
    if (count !== 0 || matchPulse || ovfPulse || periodTap !== 0) begin
      errors++;
      $display("FAIL R1: count=%h match=%b ovf=%b tap=%b expected all zero",
               count, matchPulse, ovfPulse, periodTap);
    end

    // R2 and R5: divide by one, with and without taps
    enable = 1'b1;
    curReq = "R2"; prescSel = 4'h1; run(40);
    prescSel = 4'h0; run(20);

    // R3 and R5: each power-of-two divider for three periods
    curReq = "R3";
    for (int c = 2; c <= 11; c++) begin
      prescSel = 4'(c);
      run(3 * (1 << (c - 1)) + 3);
    end
    curReq = "R5"; prescSel = 4'h1; run(1100);

    // R4: reserved codes
    curReq = "R4";
    for (int c = 12; c <= 15; c++) begin
      prescSel = 4'(c);
      run(15);
    end

    // R6: clear on match at several dividers
    curReq = "R6"; matchClr = 1'b1; cmpVal = 32'd5;
    prescSel = 4'h1; doLoad(32'd0); run(20);
    prescSel = 4'h3; doLoad(32'd2); run(40);
    cmpVal = 32'd0; prescSel = 4'h1; doLoad(32'd0); run(6);

    // R7: match without clear keeps counting
    curReq = "R7"; matchClr = 1'b0; cmpVal = 32'd9;
    prescSel = 4'h2; doLoad(32'd4); run(30);

    // R8: wrap and overflow, then a match at all-ones with clear set
    curReq = "R8"; cmpVal = 32'h1234_5678;
    prescSel = 4'h1; doLoad(32'hFFFF_FFFC); run(8);
    prescSel = 4'h4; doLoad(32'hFFFF_FFFE); run(40);
    matchClr = 1'b1; cmpVal = 32'hFFFF_FFFF;
    prescSel = 4'h1; doLoad(32'hFFFF_FFFD); run(8);
    matchClr = 1'b0;

    // R9: disabled and non-32-bit modes hold state
    curReq = "R9"; prescSel = 4'h3;
    run(5);
    enable = 1'b0; run(20);
    enable = 1'b1; run(10);
    modeSel = 2'b10; run(15);
    modeSel = 2'b01; run(5);
    modeSel = 2'b11; run(5);
    modeSel = 2'b00; run(12);

    // R10: load while disabled and load on a step clock
    curReq = "R10";
    enable = 1'b0; doLoad(32'hA5A5_0001); run(4);
    enable = 1'b1; prescSel = 4'h1; cmpVal = 32'd100;
    doLoad(32'd100); run(3);
    matchClr = 1'b0; doLoad(32'hFFFF_FFFF); doLoad(32'd7); run(5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule